// File: doc/BRIEF.md
# Microcontroller Serial Command Receiver

This block takes 8-bit commands from a control microcontroller over three wires: an enable that frames each transfer, a data line and a shift clock. While the enable is high, each rising edge of the shift clock shifts one data bit in, most significant bit first. Nothing runs when the eighth bit arrives. A command runs only when the enable falls. All three wires are asynchronous to the system clock. They are synchronised with two flip-flops each, and their edges are found digitally.

Most commands are one byte long. Two opcodes carry an operand byte. Opcode 0x70 sends the opcode and its operand inside a single enable window of 16 bits. Opcode 0x72 needs two enable windows of 8 bits each: the first carries the opcode and the second carries the operand. Every command that runs produces a one-cycle strobe along with its opcode and operand. The servo actions behind each opcode lie outside this block. Two pieces of state are kept here.

- A laser-enable output.
- A noise-rejection mode. When this mode is on, the shift clock passes through a counter filter that ignores pulses shorter than `FILT_N` system clocks.

Top module: `mcu_cmd_rx`

## Requirements
- R1: After reset, `cmd_stb_o` is 0, `laser_on_o` is 0 (laser off) and `nfilt_on_o` is 0 (filter off).
- R2: While `cmd_en_i` is high, bits on `cmd_dat_i` are taken at each rising edge of `cmd_clk_i`, most significant bit first. When the enable falls after exactly 8 bits that form an ordinary opcode, the block does four things. It pulses `cmd_stb_o` for one cycle, sets `cmd_op_o` to that byte, sets `cmd_arg_o` to 0 and sets `cmd_two_o` to 0. The pulse is high in the cycle after the third rising `clk` edge that samples `cmd_en_i` low.
- R3: One-byte command 0x0A sets `laser_on_o` to 1. One-byte command 0x8A clears it to 0. No other command changes it.
- R4: One-byte command 0xEF sets `nfilt_on_o` to 1. One-byte command 0xEE clears it to 0. Command 0xFE produces a strobe and changes no state.
- R5: A single window of exactly 16 bits whose first byte is 0x70 produces one strobe with `cmd_op_o`=0x70, `cmd_arg_o`=the second byte and `cmd_two_o`=1. If 0x70 arrives alone in an 8-bit window, no strobe is produced.
- R6: An 8-bit window holding 0x72 produces no strobe and arms a pending state. The next window of exactly 8 bits then produces a strobe with `cmd_op_o`=0x72, `cmd_arg_o`=that byte and `cmd_two_o`=1.
- R7: A window whose bit count is neither 8 nor a valid 16-bit 0x70 window produces no strobe and changes no state. This includes a window with 0 bits. Such a window also cancels a pending 0x72.
- R8: When `nfilt_on_o` is 1, a shift-clock pulse shorter than `FILT_N` system clocks is ignored. When it is 0, the same pulse shifts in a bit.
- R9: Shift-clock edges while `cmd_en_i` is low shift nothing. The bit count restarts each time the enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en_i | input | 1 | Transfer enable from the microcontroller; a command runs when it falls |
| cmd_dat_i | input | 1 | Serial command data, MSB first |
| cmd_clk_i | input | 1 | Shift clock; a bit is taken on its rising edge |
| cmd_stb_o | output | 1 | One-cycle strobe for each command that runs |
| cmd_op_o | output | 8 | Opcode of the last command that ran |
| cmd_arg_o | output | 8 | Operand of the last command that ran (0 for one-byte commands) |
| cmd_two_o | output | 1 | The last command that ran carried an operand byte |
| laser_on_o | output | 1 | Laser enable |
| nfilt_on_o | output | 1 | Shift-clock noise rejection enabled |

## Verification
The strobe, opcode, operand and the state outputs all change together, three system clocks after the enable is first sampled low. The latency scenario drives the enable low just before an edge, samples the strobe on the falling edge after two rising edges to confirm it is still 0, and samples again one rising edge later to confirm it is 1. Every other scenario waits well beyond that latency before it reads the state outputs. A monitor counts strobes and records their payload on falling clock edges, so a missing strobe or an extra strobe shows up as a wrong count. With the filter on, each shift-clock phase lasts 80 system clocks, which is more than `FILT_N` plus the synchroniser delay. Each injected glitch lasts 10 clocks.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SR_W    = 2 * BYTE_W;
  localparam int unsigned BCNT_W  = 5;

  localparam logic [BYTE_W-1:0] OP_LASER_ON  = 8'h0A;
  localparam logic [BYTE_W-1:0] OP_LASER_OFF = 8'h8A;
  localparam logic [BYTE_W-1:0] OP_NF_ON     = 8'hEF;
  localparam logic [BYTE_W-1:0] OP_NF_OFF    = 8'hEE;
  localparam logic [BYTE_W-1:0] OP_IDLE      = 8'hFE;
  localparam logic [BYTE_W-1:0] OP_ONE_WIN   = 8'h70;
  localparam logic [BYTE_W-1:0] OP_TWO_WIN   = 8'h72;
endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mcr_glitch_flt.sv
module mcr_glitch_flt #(
  parameter int unsigned FILT_N = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic bypass_i,
  output logic clk_o
);
  localparam int unsigned CW = $clog2(FILT_N + 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (raw_i != lvl_q) begin
      if (cnt_q == CW'(FILT_N - 1)) begin
        lvl_d = raw_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign clk_o = bypass_i ? raw_i : lvl_q;
endmodule

// File: rtl/mcr_shift.sv
module mcr_shift
  import mcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              dat_i,
  output logic              fall_o,
  output logic [BCNT_W-1:0] cnt_o,
  output logic [SR_W-1:0]   sr_o
);
  logic              en_q, sclk_q;
  logic [BCNT_W-1:0] cnt_q, cnt_d;
  logic [SR_W-1:0]   sr_q, sr_d;
  logic              take;

  assign take = en_i && sclk_i && !sclk_q;

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (en_i && !en_q) begin
      cnt_d = '0;
    end else if (take) begin
      sr_d = {sr_q[SR_W-2:0], dat_i};
      if (cnt_q != {BCNT_W{1'b1}}) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      en_q   <= en_i;
      sclk_q <= sclk_i;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
    end
  end

  assign fall_o = en_q && !en_i;
  assign cnt_o  = cnt_q;
  assign sr_o   = sr_q;
endmodule

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic [BCNT_W-1:0] cnt_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic              stb_o,
  output logic [BYTE_W-1:0] op_o,
  output logic [BYTE_W-1:0] arg_o,
  output logic              two_o,
  output logic              laser_o,
  output logic              nf_o
);
  logic              stb_q, stb_d, two_q, two_d, las_q, las_d, nf_q, nf_d, pend_q, pend_d;
  logic [BYTE_W-1:0] op_q, op_d, arg_q, arg_d;
  logic [BYTE_W-1:0] lo_b, hi_b;
  logic              n8, n16;

  assign lo_b = sr_i[BYTE_W-1:0];
  assign hi_b = sr_i[SR_W-1:BYTE_W];
  assign n8   = (cnt_i == BCNT_W'(BYTE_W));
  assign n16  = (cnt_i == BCNT_W'(SR_W));

  always_comb begin
    stb_d  = 1'b0;
    op_d   = op_q;
    arg_d  = arg_q;
    two_d  = two_q;
    las_d  = las_q;
    nf_d   = nf_q;
    pend_d = pend_q;
    if (fall_i) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (n8) begin
          stb_d = 1'b1;
          op_d  = OP_TWO_WIN;
          arg_d = lo_b;
          two_d = 1'b1;
        end
      end else if (n8 && lo_b == OP_TWO_WIN) begin
        pend_d = 1'b1;
      end else if (n8 && lo_b != OP_ONE_WIN) begin
        stb_d = 1'b1;
        op_d  = lo_b;
        arg_d = '0;
        two_d = 1'b0;
        case (lo_b)
          OP_LASER_ON:  las_d = 1'b1;
          OP_LASER_OFF: las_d = 1'b0;
          OP_NF_ON:     nf_d  = 1'b1;
          OP_NF_OFF:    nf_d  = 1'b0;
          default:      ;
        endcase
      end else if (n16 && hi_b == OP_ONE_WIN) begin
        stb_d = 1'b1;
        op_d  = hi_b;
        arg_d = lo_b;
        two_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      op_q   <= '0;
      arg_q  <= '0;
      two_q  <= 1'b0;
      las_q  <= 1'b0;
      nf_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      stb_q  <= stb_d;
      op_q   <= op_d;
      arg_q  <= arg_d;
      two_q  <= two_d;
      las_q  <= las_d;
      nf_q   <= nf_d;
      pend_q <= pend_d;
    end
  end

  assign stb_o   = stb_q;
  assign op_o    = op_q;
  assign arg_o   = arg_q;
  assign two_o   = two_q;
  assign laser_o = las_q;
  assign nf_o    = nf_q;
endmodule

// File: rtl/mcu_cmd_rx.sv
module mcu_cmd_rx
  import mcr_pkg::*;
#(
  parameter int unsigned FILT_N = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en_i,
  input  logic              cmd_dat_i,
  input  logic              cmd_clk_i,
  output logic              cmd_stb_o,
  output logic [BYTE_W-1:0] cmd_op_o,
  output logic [BYTE_W-1:0] cmd_arg_o,
  output logic              cmd_two_o,
  output logic              laser_on_o,
  output logic              nfilt_on_o
);
  logic [2:0]        sync_q;
  logic              sclk_f, fall;
  logic [BCNT_W-1:0] cnt;
  logic [SR_W-1:0]   sr;

  mcr_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cmd_en_i, cmd_dat_i, cmd_clk_i}),
    .q_o(sync_q)
  );

  mcr_glitch_flt #(.FILT_N(FILT_N)) u_flt (
    .clk(clk), .rst_n(rst_n),
    .raw_i(sync_q[0]), .bypass_i(!nfilt_on_o),
    .clk_o(sclk_f)
  );

  mcr_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_i(sync_q[2]), .sclk_i(sclk_f), .dat_i(sync_q[1]),
    .fall_o(fall), .cnt_o(cnt), .sr_o(sr)
  );

  mcr_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .fall_i(fall), .cnt_i(cnt), .sr_i(sr),
    .stb_o(cmd_stb_o), .op_o(cmd_op_o), .arg_o(cmd_arg_o),
    .two_o(cmd_two_o), .laser_o(laser_on_o), .nf_o(nfilt_on_o)
  );
endmodule

// File: rtl/mcu_cmd_rx_chk.sv
module mcu_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_en_i,
  input logic       cmd_stb_o,
  input logic [7:0] cmd_op_o,
  input logic       cmd_two_o,
  input logic       laser_on_o,
  input logic       nfilt_on_o
);
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |=> !cmd_stb_o); // R2

  AST_STB_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |-> (!$past(cmd_en_i, 3) && $past(cmd_en_i, 4))); // R2

  AST_LASER_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(laser_on_o) |-> (cmd_stb_o && !cmd_two_o &&
      (cmd_op_o == 8'h0A || cmd_op_o == 8'h8A))); // R3

  AST_LASER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb_o && !cmd_two_o && cmd_op_o == 8'h0A) |-> laser_on_o); // R3

  AST_NF_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nfilt_on_o) |-> (cmd_stb_o && !cmd_two_o &&
      (cmd_op_o == 8'hEF || cmd_op_o == 8'hEE))); // R4
endmodule

bind mcu_cmd_rx mcu_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_en_i(cmd_en_i), .cmd_stb_o(cmd_stb_o),
  .cmd_op_o(cmd_op_o), .cmd_two_o(cmd_two_o), .laser_on_o(laser_on_o),
  .nfilt_on_o(nfilt_on_o)
);

// File: tb/sim_mcu_cmd_rx.sv
module sim_mcu_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 80;

  logic clk, rst_n, en, dat, sclk;
  logic stb, two, las, nf;
  logic [7:0] op, arg;

  int n_chk, n_bad, n_stb;
  logic [7:0] l_op, l_arg;
  logic l_two;
  bit done;

  mcu_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .cmd_en_i(en), .cmd_dat_i(dat), .cmd_clk_i(sclk),
    .cmd_stb_o(stb), .cmd_op_o(op), .cmd_arg_o(arg), .cmd_two_o(two),
    .laser_on_o(las), .nfilt_on_o(nf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && stb) begin
      n_stb++;
      l_op  = op;
      l_arg = arg;
      l_two = two;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    dat = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic glitch();
    wait_clk(20);
    sclk = 1'b1;
    wait_clk(10);
    sclk = 1'b0;
    wait_clk(20);
  endtask

  // window with nb bits from the top of v; glitch after bit gpos if gpos >= 0
  task automatic window(input logic [15:0] v, input int nb, input int gpos);
    en = 1'b1;
    wait_clk(20);
    for (int i = 0; i < nb; i++) begin
      bit_out(v[15-i]);
      if (i == gpos) glitch();
    end
    wait_clk(20);
    en = 1'b0;
    wait_clk(20);
  endtask

  task automatic t_reset();
    check("R1 stb", stb, 0);
    check("R1 laser", las, 0);
    check("R1 nfilt", nf, 0);
  endtask

  task automatic t_latency();
    int s0;
    s0 = n_stb;
    en = 1'b1;
    wait_clk(20);
    for (int i = 0; i < 8; i++) bit_out(OPB(8'hFE, i));
    wait_clk(20);
    en = 1'b0;
    wait_clk(2);
    check("R2 stb low before 3rd edge", stb, 0);
    wait_clk(1);
    check("R2 stb high after 3rd edge", stb, 1);
    wait_clk(1);
    check("R2 stb one cycle", stb, 0);
    check("R2 op", op, 8'hFE);
    check("R2 arg", arg, 0);
    check("R2 two", two, 0);
    check("R4 idle no state change", {las, nf}, 0);
    check("R2 strobe count", n_stb - s0, 1);
    wait_clk(20);
  endtask

  function automatic logic OPB(input logic [7:0] b, input int i);
    return b[7-i];
  endfunction

  task automatic t_laser();
    window({8'h0A, 8'h00}, 8, -1);
    check("R3 laser on", las, 1);
    check("R2 op 0A", l_op, 8'h0A);
    window({8'h08, 8'h00}, 8, -1);
    check("R3 other op keeps laser", las, 1);
    window({8'h8A, 8'h00}, 8, -1);
    check("R3 laser off", las, 0);
  endtask

  task automatic t_one_win();
    int s0;
    s0 = n_stb;
    window(16'h70C3, 16, -1);
    check("R5 strobe", n_stb - s0, 1);
    check("R5 op", l_op, 8'h70);
    check("R5 arg", l_arg, 8'hC3);
    check("R5 two", l_two, 1);
    window({8'h70, 8'h00}, 8, -1);
    check("R5 lone 0x70 ignored", n_stb - s0, 1);
  endtask

  task automatic t_two_win();
    int s0;
    s0 = n_stb;
    window({8'h72, 8'h00}, 8, -1);
    check("R6 first window silent", n_stb - s0, 0);
    window({8'h5A, 8'h00}, 8, -1);
    check("R6 strobe", n_stb - s0, 1);
    check("R6 op", l_op, 8'h72);
    check("R6 arg", l_arg, 8'h5A);
    check("R6 two", l_two, 1);
  endtask

  task automatic t_bad_count();
    int s0;
    s0 = n_stb;
    window({8'h0A, 8'h00}, 7, -1);
    check("R7 seven bits no strobe", n_stb - s0, 0);
    check("R7 seven bits laser kept", las, 0);
    window(16'h0A0A, 9, -1);
    check("R7 nine bits no strobe", n_stb - s0, 0);
    window(16'h0, 0, -1);
    check("R7 empty window no strobe", n_stb - s0, 0);
    window({8'h72, 8'h00}, 8, -1);
    window({8'h33, 8'h00}, 5, -1);
    window({8'h0A, 8'h00}, 8, -1);
    check("R7 pending cancelled op", l_op, 8'h0A);
    check("R7 pending cancelled two", l_two, 0);
    check("R7 laser after cancel", las, 1);
    window({8'h8A, 8'h00}, 8, -1);
    check("R3 laser off again", las, 0);
  endtask

  task automatic t_filter();
    window({8'hEF, 8'h00}, 8, -1);
    check("R4 filter on", nf, 1);
    window({8'h0A, 8'h00}, 8, 2);
    check("R8 glitch rejected laser", las, 1);
    check("R8 glitch rejected op", l_op, 8'h0A);
    window({8'hEE, 8'h00}, 8, -1);
    check("R4 filter off", nf, 0);
    window({8'h8A, 8'h00}, 8, 2);
    check("R8 glitch counted, nine bits dropped", las, 1);
    check("R8 op unchanged", l_op, 8'hEE);
  endtask

  task automatic t_idle_clocks();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    window({8'h8A, 8'h00}, 8, -1);
    check("R9 op", l_op, 8'h8A);
    check("R9 laser off", las, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; n_stb = 0; done = 0;
    en = 0; dat = 0; sclk = 0; rst_n = 0;
    wait_clk(5);
    t_reset();
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_latency();
    t_laser();
    t_one_win();
    t_two_win();
    t_bad_count();
    t_filter();
    t_idle_clocks();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule